// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block decides which reset or interrupt an 8-bit CPU core services next and gives the address of the vector for that service. The inputs are a reset request, an indication that a software-interrupt opcode has been fetched, and six hardware interrupt sources. Each hardware source merges two request flags, and each flag has its own local enable. The CPU supplies its global interrupt mask (I bit), a self-check mode select, an instruction-boundary strobe, a busy level for its stacking sequence, a strobe when the condition code register has been stacked, and an acknowledge at the end of the vector fetch.

Hardware requests are arbitrated only at an instruction boundary. The winner is chosen by fixed priority. A one-cycle take strobe is then raised, and the vector address is latched and held until the CPU acknowledges the fetch. The block also raises a request to set the I bit. For a reset this happens at once. For a software or hardware interrupt it happens only after the condition code register has been stacked.

A software interrupt ignores the I bit, and it cannot break into a sequence that has already begun. From the cycle its opcode is fetched until its own vector fetch ends, it shuts out every hardware source. A reset request overrides everything at any time.

Top module: `irq_vector_ctrl`

## Requirements
- R1: In user mode (`self_chk`=0) the vectors are: reset $FFFE, software interrupt $FFFC, and hardware sources 0..5 at $FFFA, $FFF8, $FFF6, $FFF4, $FFF2 and $FFF0 respectively.
- R2: With `self_chk`=1, every vector address is $10 lower ($FFE0..$FFEF). The mode is sampled when the interrupt is taken.
- R3: Hardware source i owns the flag bits `src_flag[2i+1:2i]`, with matching enables in `src_en`. The source requests when any of its flags is set together with that flag's own enable.
- R4: While `i_bit`=1, no hardware source is taken.
- R5: When several hardware sources request at once, the one with the lowest index wins.
- R6: A take happens only in a cycle where `insn_bound`=1, `seq_busy`=0 and no earlier take is still waiting for `vec_ack`. `take_o` is a one-cycle pulse in the next cycle. `vector_o` stays unchanged until `vec_ack`.
- R7: `rst_req`=1 in any cycle gives, in the next cycle, `take_o`=1, `vector_o`=$FFFE and `set_i_o`=1. This holds even if a sequence is pending, and it cancels any pending software interrupt.
- R8: A software interrupt whose fetch has been accepted is taken at the next free boundary with vector $FFFC. This happens whatever the value of `i_bit`, and it wins over any pending hardware source.
- R9: From the cycle `swi_fetch` is accepted until the software-interrupt vector fetch is acknowledged, no hardware source is taken. This includes a boundary in the same cycle as the fetch.
- R10: `swi_fetch` has no effect while a take waits for `vec_ack`, or while `seq_busy`=1.
- R11: For a software or hardware take, `set_i_o` stays 0 in the take cycle. It pulses for one cycle after the cycle in which `ccr_stacked`=1 while the take is outstanding.
- R12: After `rst`, `take_o`=0, `set_i_o`=0 and `vector_o`=$0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| rst_req | input | 1 | Reset request from the chip reset sources |
| swi_fetch | input | 1 | Software-interrupt opcode fetched |
| insn_bound | input | 1 | Instruction boundary, the arbitration point |
| seq_busy | input | 1 | CPU interrupt sequence already in progress |
| vec_ack | input | 1 | End of vector fetch |
| ccr_stacked | input | 1 | Condition code register has been stacked |
| i_bit | input | 1 | Global interrupt mask from the CPU |
| self_chk | input | 1 | Self-check mode, moves the vector table down |
| src_flag | input | 12 | Hardware request flags, two per source |
| src_en | input | 12 | Local enable for each flag |
| take_o | output | 1 | Take-interrupt strobe |
| vector_o | output | 16 | Latched vector address |
| set_i_o | output | 1 | Request to set the I bit |

## Verification
The hardest case to reach is the software-interrupt lockout while a hardware source is already pending. To set it up, the bench raises `swi_fetch` in the same cycle as an instruction boundary, with an enabled flag present and the I bit clear. It then confirms that no take happens in that cycle, that the next boundary yields $FFFC, and that the hardware source is taken only after the acknowledge. Further stimulus holds a take outstanding while inputs change, to show that the latched vector and mode stay put. Finally, `rst_req` arrives in the middle of a sequence.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    typedef struct packed {
        logic       valid;
        logic [7:0] idx;
    } src_pick_t;

    function automatic logic [15:0] vec_addr(input logic [15:0] base,
                                             input logic [7:0]  slot);
        return base | {7'd0, slot, 1'b0};
    endfunction

endpackage

// File: rtl/irqv_src_merge.sv
module irqv_src_merge #(
    parameter int FPS = 2
) (
    input  logic [FPS-1:0] flag,
    input  logic [FPS-1:0] en,
    output logic           req
);
    assign req = |(flag & en);
endmodule

// File: rtl/irqv_prio.sv
module irqv_prio
    import irqv_pkg::*;
#(
    parameter int N = 6
) (
    input  logic [N-1:0] req,
    output src_pick_t    pick
);
    always_comb begin
        pick = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                pick.valid = 1'b1;
                pick.idx   = 8'(i);
            end
        end
    end

    always_comb begin
        if (pick.valid) begin
            AST_PRIO_HIT: assert (req[pick.idx[$clog2(N)-1:0]]); // R5
        end
    end
endmodule

// File: rtl/irqv_seq.sv
module irqv_seq
    import irqv_pkg::*;
#(
    parameter int          N_HW      = 6,
    parameter logic [15:0] USER_BASE = 16'hFFF0,
    parameter logic [15:0] TEST_BASE = 16'hFFE0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rst_req,
    input  logic        swi_fetch,
    input  logic        insn_bound,
    input  logic        seq_busy,
    input  logic        vec_ack,
    input  logic        ccr_stacked,
    input  logic        i_bit,
    input  logic        self_chk,
    input  src_pick_t   hw_pick,
    output logic        take_o,
    output logic [15:0] vector_o,
    output logic        set_i_o
);
    localparam logic [7:0] SLOT_RST = 8'(N_HW + 1);
    localparam logic [7:0] SLOT_SWI = 8'(N_HW);
    localparam logic [7:0] SLOT_HW0 = 8'(N_HW - 1);

    logic        hold_q, hold_rst_q, swi_pend_q, take_q, set_i_q;
    logic [15:0] vec_q;
    logic        can_arb, swi_accept, take_swi, take_hw;
    logic [15:0] base;
    logic [7:0]  slot;

    assign base       = self_chk ? TEST_BASE : USER_BASE;
    assign can_arb    = insn_bound & ~seq_busy & ~hold_q;
    assign swi_accept = swi_fetch & ~hold_q & ~seq_busy & ~swi_pend_q;
    assign take_swi   = can_arb & swi_pend_q;
    assign take_hw    = can_arb & ~swi_pend_q & ~swi_accept & hw_pick.valid & ~i_bit;
    assign slot       = take_swi ? SLOT_SWI : (SLOT_HW0 - hw_pick.idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q     <= 1'b0;
            hold_rst_q <= 1'b0;
            swi_pend_q <= 1'b0;
            take_q     <= 1'b0;
            set_i_q    <= 1'b0;
            vec_q      <= '0;
        end else if (rst_req) begin
            hold_q     <= 1'b1;
            hold_rst_q <= 1'b1;
            swi_pend_q <= 1'b0;
            take_q     <= 1'b1;
            set_i_q    <= 1'b1;
            vec_q      <= vec_addr(base, SLOT_RST);
        end else begin
            take_q  <= take_swi | take_hw;
            set_i_q <= hold_q & ccr_stacked & ~hold_rst_q;
            if (take_swi | take_hw) begin
                hold_q     <= 1'b1;
                hold_rst_q <= 1'b0;
                vec_q      <= vec_addr(base, slot);
            end else if (hold_q && vec_ack) begin
                hold_q <= 1'b0;
            end
            if (take_swi)        swi_pend_q <= 1'b0;
            else if (swi_accept) swi_pend_q <= 1'b1;
        end
    end

    assign take_o   = take_q;
    assign vector_o = vec_q;
    assign set_i_o  = set_i_q;

    AST_TAKE_AT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (!rst_req && !insn_bound) |=> !take_o); // R6
    AST_VEC_HELD: assert property (@(posedge clk) disable iff (rst)
        (hold_q && !vec_ack && !rst_req) |=> $stable(vector_o)); // R6
    AST_RST_WINS: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> (take_o && set_i_o && vector_o[3:0] == 4'hE)); // R7
    AST_MASKED: assert property (@(posedge clk) disable iff (rst)
        (i_bit && !rst_req && !swi_pend_q) |=> !take_o); // R4
    AST_SETI_LATE: assert property (@(posedge clk) disable iff (rst)
        (!rst_req && !(hold_q && ccr_stacked)) |=> !set_i_o); // R11
    AST_SWI_LOCK: assert property (@(posedge clk) disable iff (rst)
        (swi_pend_q && !rst_req) |=> (!take_o || vector_o[3:0] == 4'hC)); // R9
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqv_pkg::*;
#(
    parameter int          N_HW      = 6,
    parameter int          FPS       = 2,
    parameter logic [15:0] USER_BASE = 16'hFFF0,
    parameter logic [15:0] TEST_BASE = 16'hFFE0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rst_req,
    input  logic                swi_fetch,
    input  logic                insn_bound,
    input  logic                seq_busy,
    input  logic                vec_ack,
    input  logic                ccr_stacked,
    input  logic                i_bit,
    input  logic                self_chk,
    input  logic [N_HW*FPS-1:0] src_flag,
    input  logic [N_HW*FPS-1:0] src_en,
    output logic                take_o,
    output logic [15:0]         vector_o,
    output logic                set_i_o
);
    logic [N_HW-1:0] hw_req;
    src_pick_t       hw_pick;

    for (genvar g = 0; g < N_HW; g++) begin : g_src
        irqv_src_merge #(.FPS(FPS)) u_merge (
            .flag (src_flag[g*FPS +: FPS]),
            .en   (src_en[g*FPS +: FPS]),
            .req  (hw_req[g])
        );
    end

    irqv_prio #(.N(N_HW)) u_prio (
        .req  (hw_req),
        .pick (hw_pick)
    );

    irqv_seq #(
        .N_HW      (N_HW),
        .USER_BASE (USER_BASE),
        .TEST_BASE (TEST_BASE)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .rst_req     (rst_req),
        .swi_fetch   (swi_fetch),
        .insn_bound  (insn_bound),
        .seq_busy    (seq_busy),
        .vec_ack     (vec_ack),
        .ccr_stacked (ccr_stacked),
        .i_bit       (i_bit),
        .self_chk    (self_chk),
        .hw_pick     (hw_pick),
        .take_o      (take_o),
        .vector_o    (vector_o),
        .set_i_o     (set_i_o)
    );
endmodule

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst, rst_req, swi_fetch, insn_bound, seq_busy, vec_ack;
    logic        ccr_stacked, i_bit, self_chk;
    logic [11:0] src_flag, src_en;
    logic        take_o, set_i_o;
    logic [15:0] vector_o;
    int          n_run = 0, n_fail = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    irq_vector_ctrl u_irq_vector_ctrl (
        .clk(clk), .rst(rst), .rst_req(rst_req), .swi_fetch(swi_fetch),
        .insn_bound(insn_bound), .seq_busy(seq_busy), .vec_ack(vec_ack),
        .ccr_stacked(ccr_stacked), .i_bit(i_bit), .self_chk(self_chk),
        .src_flag(src_flag), .src_en(src_en), .take_o(take_o),
        .vector_o(vector_o), .set_i_o(set_i_o)
    );

    // {flags, enables, i_bit, self_chk, exp_take, exp_vector}
    localparam logic [42:0] TBL [0:9] = '{
        {12'h001, 12'hFFF, 1'b0, 1'b0, 1'b1, 16'hFFFA},  // R1 source 0
        {12'h820, 12'hFFF, 1'b0, 1'b0, 1'b1, 16'hFFF6},  // R3 R5 second flag, src2 over src5
        {12'hFFF, 12'hFFF, 1'b0, 1'b0, 1'b1, 16'hFFFA},  // R5 all at once
        {12'h101, 12'hFFE, 1'b0, 1'b0, 1'b1, 16'hFFF2},  // R3 disabled flag skipped
        {12'hFFF, 12'hFFF, 1'b1, 1'b0, 1'b0, 16'h0000},  // R4 masked
        {12'h004, 12'hFFF, 1'b0, 1'b1, 1'b1, 16'hFFE8},  // R2 self-check
        {12'h400, 12'hFFF, 1'b0, 1'b1, 1'b1, 16'hFFE0},  // R2 lowest slot
        {12'h080, 12'hFFF, 1'b0, 1'b0, 1'b1, 16'hFFF4},  // R1 source 3
        {12'h000, 12'hFFF, 1'b0, 1'b0, 1'b0, 16'h0000},  // R6 nothing pending
        {12'h00C, 12'hFF3, 1'b0, 1'b0, 1'b0, 16'h0000}   // R3 both flags disabled
    };

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic boundary();
        insn_bound = 1'b1;
        cyc();
        insn_bound = 1'b0;
    endtask

    task automatic ack();
        vec_ack = 1'b1;
        cyc();
        vec_ack = 1'b0;
    endtask

    initial begin
        #(10 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; rst_req = 0; swi_fetch = 0; insn_bound = 0; seq_busy = 0;
        vec_ack = 0; ccr_stacked = 0; i_bit = 0; self_chk = 0;
        src_flag = '0; src_en = '0;
        cyc(); cyc();
        rst = 1'b0;
        cyc();
        chk("R12 take", {15'd0, take_o}, 16'd0);
        chk("R12 set_i", {15'd0, set_i_o}, 16'd0);
        chk("R12 vector", vector_o, 16'h0000);

        foreach (TBL[k]) begin
            src_flag = TBL[k][42:31]; src_en = TBL[k][30:19];
            i_bit = TBL[k][18]; self_chk = TBL[k][17];
            boundary();
            chk($sformatf("R1-table entry %0d take", k), {15'd0, take_o}, {15'd0, TBL[k][16]});
            if (TBL[k][16]) begin
                chk($sformatf("R1 table entry %0d vector", k), vector_o, TBL[k][15:0]);
                chk("R11 no set_i at take", {15'd0, set_i_o}, 16'd0);
                ack();
            end
        end

        // R6 hold: vector and mode held, no second take until ack
        src_flag = 12'h001; src_en = 12'hFFF; i_bit = 0; self_chk = 0;
        boundary();
        chk("R6 first take", vector_o, 16'hFFFA);
        src_flag = 12'h400; self_chk = 1;
        boundary();
        chk("R6 no take while holding", {15'd0, take_o}, 16'd0);
        chk("R2 R6 vector held", vector_o, 16'hFFFA);
        // R11 set_i follows stacking
        ccr_stacked = 1; cyc(); ccr_stacked = 0;
        chk("R11 set_i after stack", {15'd0, set_i_o}, 16'd1);
        cyc();
        chk("R11 set_i one pulse", {15'd0, set_i_o}, 16'd0);
        ack();
        self_chk = 0; src_flag = '0;

        // R6 seq_busy blocks arbitration
        src_flag = 12'h010; seq_busy = 1;
        boundary();
        chk("R6 busy no take", {15'd0, take_o}, 16'd0);
        seq_busy = 0;
        boundary();
        chk("R6 after busy", vector_o, 16'hFFF6);
        ack();

        // R9 SWI fetch at a boundary with hardware pending; R8 with I set later
        src_flag = 12'h001; i_bit = 0;
        swi_fetch = 1; insn_bound = 1; cyc(); swi_fetch = 0; insn_bound = 0;
        chk("R9 no hw take at fetch", {15'd0, take_o}, 16'd0);
        i_bit = 1;
        boundary();
        chk("R8 swi take", {15'd0, take_o}, 16'd1);
        chk("R8 swi vector", vector_o, 16'hFFFC);
        chk("R11 swi no set_i at take", {15'd0, set_i_o}, 16'd0);
        // R10 fetch during hold ignored
        swi_fetch = 1; cyc(); swi_fetch = 0;
        ccr_stacked = 1; cyc(); ccr_stacked = 0;
        chk("R11 swi set_i", {15'd0, set_i_o}, 16'd1);
        ack();
        i_bit = 0;
        boundary();
        chk("R9 hw after lockout", vector_o, 16'hFFFA);
        ack();
        src_flag = '0;
        boundary();
        chk("R10 ignored fetch", {15'd0, take_o}, 16'd0);

        // R10 fetch while seq_busy ignored
        seq_busy = 1; swi_fetch = 1; cyc(); swi_fetch = 0; seq_busy = 0;
        boundary();
        chk("R10 busy fetch ignored", {15'd0, take_o}, 16'd0);

        // R7 reset request mid-sequence, cancels a pending SWI
        src_flag = 12'h004;
        boundary();
        chk("R7 setup", vector_o, 16'hFFF8);
        swi_fetch = 0;
        rst_req = 1; cyc(); rst_req = 0;
        chk("R7 take", {15'd0, take_o}, 16'd1);
        chk("R7 vector", vector_o, 16'hFFFE);
        chk("R7 set_i", {15'd0, set_i_o}, 16'd1);
        ack();
        src_flag = '0;
        swi_fetch = 1; cyc(); swi_fetch = 0;
        rst_req = 1; cyc(); rst_req = 0;
        ack();
        boundary();
        chk("R7 swi cancelled", {15'd0, take_o}, 16'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule